// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block turns a bank of already-synchronized pin levels into one interrupt line. Each pin has its own two-bit trigger code. The code picks detection of rising edges, falling edges, or both, or it turns detection off. Level-sensitive triggering is not offered. An edge is found by comparing the level seen at a clock edge with the level seen one clock earlier. A qualifying edge latches a bit in a sticky status register. Software clears that bit by writing a one to it.

A mask register sits next to the status register. Software sets mask bits through one address and clears them through another, so neither action needs a read-modify-write. The interrupt output is high while any status bit is set whose mask bit is clear. Status bits keep latching while a pin is masked, so an edge that arrives while masked shows up on the interrupt line as soon as the pin is unmasked. Software reaches the block through a one-cycle write strobe and a read strobe. A read returns its data one clock after the strobe.

Top module: `gpio_edge_irq`

## Requirements
- R1: At reset every mask bit is 1, every status bit is 0, every trigger code is 00 and `irq` is low.
- R2: Word address p (0 to NPIN-1) is pin p's control register. A write stores `wr_data[4:3]` as that pin's trigger code and ignores all other bits. A read returns the code in bits 4:3 and zero in all other bits.
- R3: With trigger code 01, the pin's status bit is set at the first clock edge that samples the pin at 1 when the previous clock edge sampled it at 0.
- R4: With trigger code 10, the status bit is set at the clock edge that samples 0 after a sample of 1.
- R5: With trigger code 11, the status bit is set at the clock edge that samples either transition.
- R6: With trigger code 00, the pin never sets its status bit.
- R7: Writing to word address NPIN (status) clears each status bit whose written bit is 1. Written zeros leave status unchanged. A read of this address returns the status.
- R8: If a qualifying edge and a clear of the same bit fall in the same cycle, the bit is set after that clock edge.
- R9: Writing to word address NPIN+1 sets each mask bit whose written bit is 1. Written zeros have no effect. Reads of address NPIN+1 or NPIN+2 return the mask.
- R10: Writing to word address NPIN+2 clears each mask bit whose written bit is 1. Written zeros have no effect.
- R11: `irq` is 1 exactly while some status bit is 1 and its mask bit is 0. Status bits latch edges regardless of the mask.
- R12: When `rd_en` is high at a clock edge, `rd_data` holds, after that edge, the value the addressed register had before the edge. Addresses above NPIN+2 read as 0. Between reads, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPIN | Synchronized pin levels |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW | Write word address |
| wr_data | input | NPIN | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| rd_data | output | NPIN | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is an edge that lands in the same cycle as a software clear of the same bit. The pin must change between two samples exactly when the status write is strobed, and the pin's trigger code must already be set up. A directed sequence primes pin 0 for rising edges, holds it low, and then raises it in the very cycle that writes a one to its status bit. A second directed case latches an edge while the pin is masked and then unmasks it. Random traffic mixes pin toggles with writes to every address, so the same collisions recur with other trigger codes.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPIN = 32,
  localparam int AW = $clog2(NPIN + 3),
  localparam int PW = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NPIN-1:0] wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [NPIN-1:0] rd_data,
  output logic            irq
);
  localparam logic [AW-1:0] STAT_A = AW'(NPIN);
  localparam logic [AW-1:0] MSET_A = AW'(NPIN + 1);
  localparam logic [AW-1:0] MCLR_A = AW'(NPIN + 2);

  logic [1:0]      trig [NPIN];
  logic [NPIN-1:0] prev, status, mask, hit, trig_off;
  logic [NPIN-1:0] st_clr, m_set, m_clr, rd_mux;

  assign st_clr = (wr_en && wr_addr == STAT_A) ? wr_data : '0;
  assign m_set  = (wr_en && wr_addr == MSET_A) ? wr_data : '0;
  assign m_clr  = (wr_en && wr_addr == MCLR_A) ? wr_data : '0;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk)
      if (!rst_n) trig[i] <= 2'b00;
      else if (wr_en && wr_addr == AW'(i)) trig[i] <= wr_data[4:3];

    assign hit[i] = (trig[i][0] & ~prev[i] &  pin_lvl[i]) |
                    (trig[i][1] &  prev[i] & ~pin_lvl[i]);
    assign trig_off[i] = (trig[i] == 2'b00);
  end

  always_ff @(posedge clk) begin
    prev <= pin_lvl;
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~st_clr) | hit;
      mask   <= (mask | m_set) & ~m_clr;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr < STAT_A)       rd_mux[4:3] = trig[rd_addr[PW-1:0]];
    else if (rd_addr == STAT_A) rd_mux = status;
    else if (rd_addr == MSET_A || rd_addr == MCLR_A) rd_mux = mask;
  end

  always_ff @(posedge clk)
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;

  assign irq = |(status & ~mask);

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);

  assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(st_clr)) & ~status) == '0));

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(hit)) == $past(hit)));

  assert_off_pin_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(trig_off)) == '0));

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MSET_A) |=> ((mask & $past(wr_data)) == $past(wr_data)));

  assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MCLR_A) |=> ((mask & $past(wr_data)) == '0));

  assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
  localparam int N = 32;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_lvl = '0, wr_data = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [N-1:0] rd_data;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  bit [1:0]   m_trig [N];
  bit [N-1:0] m_stat, m_mask, m_prev;

  always #10 clk = ~clk;

  gpio_edge_irq #(.NPIN(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  function automatic bit [N-1:0] rd_model(input bit [AW-1:0] a);
    if (a < N) return {27'b0, m_trig[a[4:0]], 3'b0};
    if (a == N) return m_stat;
    if (a == N + 1 || a == N + 2) return m_mask;
    return '0;
  endfunction

  function automatic bit [N-1:0] hits_model(input bit [N-1:0] p);
    bit [N-1:0] h = '0;
    for (int i = 0; i < N; i++) begin
      bit rise = !m_prev[i] && p[i];
      bit fall = m_prev[i] && !p[i];
      case (m_trig[i])
        2'b01: h[i] = rise;
        2'b10: h[i] = fall;
        2'b11: h[i] = rise || fall;
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit [N-1:0] p, input bit we, input bit [AW-1:0] wa,
                      input bit [N-1:0] wd, input bit re, input bit [AW-1:0] ra,
                      input string tag);
    bit [N-1:0] exp_rd, h, nst, nmask;
    pin_lvl = p; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    exp_rd = rd_model(ra);
    h = hits_model(p);
    nst = (m_stat & ~((we && wa == N) ? wd : '0)) | h;
    nmask = (m_mask | ((we && wa == N + 1) ? wd : '0)) & ~((we && wa == N + 2) ? wd : '0);
    @(posedge clk); #1;
    m_stat = nst; m_mask = nmask; m_prev = p;
    if (we && wa < N) m_trig[wa[4:0]] = wd[4:3];
    chk({31'b0, irq}, {31'b0, |(m_stat & ~m_mask)}, {tag, " irq (R11)"});
    if (re) chk(rd_data, exp_rd, {tag, " read (R12)"});
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) m_trig[i] = 2'b00;
    m_stat = '0; m_mask = '1; m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    chk({31'b0, irq}, 32'h0, "R1 irq after reset");
    step('0, 0, 0, 0, 1, 33, "R1 mask reset");
    chk(rd_data, 32'hFFFF_FFFF, "R1 mask all ones");
    step('0, 0, 0, 0, 1, 32, "R1 status reset");
    chk(rd_data, 32'h0, "R1 status zero");
    step('0, 0, 0, 0, 1, 5, "R1 trigger reset");
    chk(rd_data, 32'h0, "R1 trigger 00");

    step('0, 1, 3, 32'hFFFF_FFFF, 0, 0, "R2 write");
    step('0, 0, 0, 0, 1, 3, "R2 read");
    chk(rd_data, 32'h18, "R2 only bits 4:3");

    step('0, 1, 0, 32'h08, 0, 0, "R3 cfg");
    step('0, 1, 34, 32'h1, 0, 0, "R10 unmask0");
    step(32'h1, 0, 0, 0, 0, 0, "R3 rise");
    chk({31'b0, irq}, 32'h1, "R3 rising sets irq");
    step(32'h1, 0, 0, 0, 1, 32, "R3 read");
    chk(rd_data, 32'h1, "R3 status bit0");
    step(32'h1, 1, 32, 32'h1, 0, 0, "R7 clear");
    step(32'h0, 0, 0, 0, 1, 32, "R3 fall ignored");
    step(32'h0, 0, 0, 0, 1, 32, "R3 read");
    chk(rd_data, 32'h0, "R3 fall no set");

    step(32'h2, 1, 1, 32'h10, 0, 0, "R4 cfg");
    step(32'h0, 1, 34, 32'h2, 0, 0, "R4 fall");
    step(32'h0, 0, 0, 0, 1, 32, "R4 read");
    chk(rd_data, 32'h2, "R4 falling sets bit1");

    step(32'h0, 1, 2, 32'h18, 0, 0, "R5 cfg");
    step(32'h4, 0, 0, 0, 0, 0, "R5 rise");
    step(32'h4, 0, 0, 0, 1, 32, "R5 read");
    chk(rd_data, 32'h6, "R5 rise sets bit2");
    step(32'h4, 1, 32, 32'h4, 0, 0, "R5 clear");
    step(32'h0, 0, 0, 0, 0, 0, "R5 fall");
    step(32'h0, 0, 0, 0, 1, 32, "R5 read");
    chk(rd_data, 32'h6, "R5 fall sets bit2");

    step(32'h40, 0, 0, 0, 0, 0, "R6 toggle");
    step(32'h0, 0, 0, 0, 0, 0, "R6 toggle");
    step(32'h0, 0, 0, 0, 1, 32, "R6 read");
    chk(rd_data, 32'h6, "R6 code 00 no set");

    step(32'h0, 1, 32, 32'h0, 1, 32, "R7 zero write");
    step(32'h0, 0, 0, 0, 1, 32, "R7 read");
    chk(rd_data, 32'h6, "R7 zeros no effect");
    step(32'h0, 1, 32, 32'hFFFF_FFFF, 0, 0, "R7 clear all");

    step(32'h1, 1, 32, 32'h1, 0, 0, "R8 collide");
    step(32'h1, 0, 0, 0, 1, 32, "R8 read");
    chk(rd_data, 32'h1, "R8 edge wins over clear");

    step(32'h1, 1, 33, 32'hFFFF_FFFF, 0, 0, "R9 mask all");
    chk({31'b0, irq}, 32'h0, "R9 masked irq low");
    step(32'h1, 1, 33, 32'h0, 1, 33, "R9 zero set");
    step(32'h1, 0, 0, 0, 1, 34, "R9 read");
    chk(rd_data, 32'hFFFF_FFFF, "R9 mask all ones");

    step(32'h1, 1, 32, 32'h1, 0, 0, "R11 clear");
    step(32'h0, 0, 0, 0, 0, 0, "R11 low");
    step(32'h1, 0, 0, 0, 0, 0, "R11 masked rise");
    chk({31'b0, irq}, 32'h0, "R11 masked edge no irq");
    step(32'h1, 1, 34, 32'h1, 0, 0, "R10 unmask");
    chk({31'b0, irq}, 32'h1, "R10 unmask shows latched edge");
    step(32'h1, 1, 34, 32'h0, 1, 33, "R10 zero clear");
    chk(rd_data, 32'hFFFF_FFFE, "R10 mask bit0 clear");
    step(32'h1, 0, 0, 0, 1, 40, "R12 unmapped");
    chk(rd_data, 32'h0, "R12 unmapped reads 0");

    for (int k = 0; k < 4000; k++) begin
      bit [N-1:0] p = m_prev ^ ($urandom & $urandom & $urandom);
      bit we = ($urandom_range(0, 2) == 0);
      bit [AW-1:0] wa = AW'($urandom_range(0, 36));
      bit [N-1:0] wd = $urandom;
      bit re = $urandom_range(0, 1);
      bit [AW-1:0] ra = AW'($urandom_range(0, 36));
      step(p, we, wa, wd, re, ra, "R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule